// File: doc/BRIEF.md
# Serial Port FIFO Controller

This block sits between the 32-bit data port of a register bus and a synchronous serial shift engine. It has a transmit FIFO, which the bus fills and the engine drains, and a receive FIFO, which the engine fills and the bus drains. Each FIFO is 32 entries of 32 bits. Each FIFO has a programmable trigger level. The level drives an interrupt line and a DMA service request, and each DMA request has its own enable.

The word can be reordered in one of four ways as it crosses the bus port. One selector acts on writes going into the transmit FIFO and a separate selector acts on reads coming from the receive FIFO. While the receive FIFO is full, the block can tell a master-mode engine to halt, and it releases the engine as soon as an entry is read.

A test mode routes both bus writes and bus reads to a single chosen FIFO. While test mode is on, the engine-side handshakes are ignored. A bus write that finds its target full, or a bus read that finds its target empty, is dropped and sets a sticky error flag.

Top module: `spfifo_ctrl`

## Requirements
- R1: After reset both levels read 0 and `err` is 0. `tx_irq` is 1 because an empty transmit FIFO is at or below any trigger. `rx_irq`, `eng_halt`, `eng_tx_valid` and both DMA requests are 0.
- R2: Each FIFO holds 32 words and is first-in first-out. In normal mode (`cfg_test_en`=0), a bus write pushes the transmit FIFO and `eng_tx_valid && eng_tx_ready` pops it. `eng_rx_valid && eng_rx_ready` pushes the receive FIFO and a bus read pops it. `tx_level` and `rx_level` give the current entry counts.
- R3: Bus write data is reordered by `cfg_wr_order` before it is stored. Writing the input bytes as B3 B2 B1 B0 (B3 = bits 31:24), the stored word is:
  - 0 → B3 B2 B1 B0
  - 1 → B1 B0 B3 B2
  - 2 → B0 B1 B2 B3
  - 3 → B2 B3 B0 B1
- R4: `bus_rdata` shows the head of the FIFO that a read would pop, reordered by `cfg_rd_order` with the same four mappings as R3. The engine sees transmit words exactly as they were stored.
- R5: `tx_irq` is 1 exactly when `tx_level` is at most `cfg_tx_lvl`+1.
- R6: `rx_irq` is 1 exactly when `rx_level` is at least `cfg_rx_lvl`+1.
- R7: `tx_dma_req` equals `tx_irq` AND `cfg_tx_dma_en`, and `rx_dma_req` equals `rx_irq` AND `cfg_rx_dma_en`. A request with its enable at 0 stays low.
- R8: A bus write to a full target or a bus read from an empty target leaves the FIFO unchanged and sets `err`, which then stays 1 until reset. A read from an empty target shows `bus_rdata` = 0.
- R9: `eng_halt` is 1 exactly when `cfg_stall_en` and `eng_master` are both 1 and the receive FIFO holds 32 entries. In normal mode, `eng_rx_ready` is the inverse of receive-full.
- R10: With `cfg_test_en`=1, bus writes and bus reads both act on the transmit FIFO when `cfg_test_sel`=0 and on the receive FIFO when it is 1. `eng_tx_valid` and `eng_rx_ready` are held at 0, so `eng_tx_ready` and `eng_rx_valid` change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_tx_lvl | input | 5 | Transmit trigger, level minus one |
| cfg_rx_lvl | input | 5 | Receive trigger, level minus one |
| cfg_tx_dma_en | input | 1 | Transmit DMA request enable |
| cfg_rx_dma_en | input | 1 | Receive DMA request enable |
| cfg_wr_order | input | 2 | Write-path reorder select |
| cfg_rd_order | input | 2 | Read-path reorder select |
| cfg_stall_en | input | 1 | Halt the engine while receive FIFO is full |
| cfg_test_en | input | 1 | Test mode: bus port drives one FIFO |
| cfg_test_sel | input | 1 | Test target: 0 transmit, 1 receive |
| bus_wr | input | 1 | Data-port write strobe |
| bus_wdata | input | 32 | Data-port write data |
| bus_rd | input | 1 | Data-port read strobe (pops on the clock edge) |
| bus_rdata | output | 32 | Data-port read data |
| eng_tx_valid | output | 1 | Transmit word available to engine |
| eng_tx_data | output | 32 | Transmit word to engine |
| eng_tx_ready | input | 1 | Engine takes transmit word |
| eng_rx_valid | input | 1 | Engine offers received word |
| eng_rx_data | input | 32 | Received word from engine |
| eng_rx_ready | output | 1 | Receive FIFO accepts a word |
| eng_master | input | 1 | Engine is in master mode |
| eng_halt | output | 1 | Engine must idle and stop the serial clock |
| tx_irq | output | 1 | Transmit trigger reached |
| rx_irq | output | 1 | Receive trigger reached |
| tx_dma_req | output | 1 | Gated transmit DMA request |
| rx_dma_req | output | 1 | Gated receive DMA request |
| err | output | 1 | Sticky overflow/underflow flag |
| tx_level | output | 6 | Transmit FIFO entry count |
| rx_level | output | 6 | Receive FIFO entry count |

## Verification
The assertions assume that the configuration inputs change only between transfers, and that an overflow check on the transmit side applies only when the engine is not popping in the same cycle. The bench changes the configuration only at phase boundaries. Its random phases are biased so that each FIFO is driven to full and to empty, and so that bus reads and writes hit those boundaries in both normal mode and test mode.

// File: rtl/spfifo_ctrl.sv
module spfifo_ctrl #(
  parameter int DEPTH = 32,
  parameter int LW    = 5,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] cfg_tx_lvl,
  input  logic [LW-1:0] cfg_rx_lvl,
  input  logic          cfg_tx_dma_en,
  input  logic          cfg_rx_dma_en,
  input  logic [1:0]    cfg_wr_order,
  input  logic [1:0]    cfg_rd_order,
  input  logic          cfg_stall_en,
  input  logic          cfg_test_en,
  input  logic          cfg_test_sel,
  input  logic          bus_wr,
  input  logic [31:0]   bus_wdata,
  input  logic          bus_rd,
  output logic [31:0]   bus_rdata,
  output logic          eng_tx_valid,
  output logic [31:0]   eng_tx_data,
  input  logic          eng_tx_ready,
  input  logic          eng_rx_valid,
  input  logic [31:0]   eng_rx_data,
  output logic          eng_rx_ready,
  input  logic          eng_master,
  output logic          eng_halt,
  output logic          tx_irq,
  output logic          rx_irq,
  output logic          tx_dma_req,
  output logic          rx_dma_req,
  output logic          err,
  output logic [CW-1:0] tx_level,
  output logic [CW-1:0] rx_level
);

  function automatic logic [31:0] reorder(input logic [1:0] m, input logic [31:0] w);
    case (m)
      2'd0:    return w;
      2'd1:    return {w[15:0], w[31:16]};
      2'd2:    return {w[7:0], w[15:8], w[23:16], w[31:24]};
      default: return {w[23:16], w[31:24], w[7:0], w[15:8]};
    endcase
  endfunction

  logic [1:0]      push, pop, full, empty;
  logic [63:0]     din_v, head_v;
  logic [2*CW-1:0] cnt_v;
  logic [31:0]     wdata_r, rd_head;
  logic            to_tx_w, to_rx_w, rd_tx, rd_rx, rd_empty, bad;

  assign wdata_r = reorder(cfg_wr_order, bus_wdata);

  assign to_tx_w = bus_wr & ~(cfg_test_en & cfg_test_sel);
  assign to_rx_w = bus_wr & cfg_test_en & cfg_test_sel;
  assign rd_tx   = bus_rd & cfg_test_en & ~cfg_test_sel;
  assign rd_rx   = bus_rd & ~(cfg_test_en & ~cfg_test_sel);

  assign push[0] = to_tx_w & ~full[0];
  assign pop[0]  = (cfg_test_en ? rd_tx : eng_tx_ready) & ~empty[0];
  assign push[1] = (cfg_test_en ? to_rx_w : eng_rx_valid) & ~full[1];
  assign pop[1]  = rd_rx & ~empty[1];

  assign din_v[31:0]  = wdata_r;
  assign din_v[63:32] = cfg_test_en ? wdata_r : eng_rx_data;

  for (genvar g = 0; g < 2; g++) begin : g_fifo
    logic [31:0]   mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
      if (push[g]) mem[wp] <= din_v[g*32 +: 32];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (push[g]) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
        if (pop[g])  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
        if (push[g] && !pop[g])      cnt <= cnt + 1'b1;
        else if (pop[g] && !push[g]) cnt <= cnt - 1'b1;
      end
    end

    assign full[g]              = (cnt == CW'(DEPTH));
    assign empty[g]             = (cnt == '0);
    assign head_v[g*32 +: 32]   = mem[rp];
    assign cnt_v[g*CW +: CW]    = cnt;
  end

  assign tx_level = cnt_v[CW-1:0];
  assign rx_level = cnt_v[2*CW-1:CW];

  assign bad = (to_tx_w & full[0]) | (to_rx_w & full[1]) |
               (rd_tx & empty[0]) | (rd_rx & empty[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   err <= 1'b0;
    else if (bad) err <= 1'b1;
  end

  assign rd_head   = (cfg_test_en & ~cfg_test_sel) ? head_v[31:0] : head_v[63:32];
  assign rd_empty  = (cfg_test_en & ~cfg_test_sel) ? empty[0] : empty[1];
  assign bus_rdata = rd_empty ? 32'd0 : reorder(cfg_rd_order, rd_head);

  assign eng_tx_valid = ~cfg_test_en & ~empty[0];
  assign eng_tx_data  = head_v[31:0];
  assign eng_rx_ready = ~cfg_test_en & ~full[1];
  assign eng_halt     = cfg_stall_en & eng_master & full[1];

  assign tx_irq     = int'(tx_level) <= int'(cfg_tx_lvl) + 1;
  assign rx_irq     = int'(rx_level) >= int'(cfg_rx_lvl) + 1;
  assign tx_dma_req = tx_irq & cfg_tx_dma_en;
  assign rx_dma_req = rx_irq & cfg_rx_dma_en;

endmodule

// File: rtl/spfifo_ctrl_chk.sv
module spfifo_ctrl_chk #(
  parameter int DEPTH = 32,
  parameter int CW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_tx_dma_en,
  input logic          cfg_rx_dma_en,
  input logic          cfg_stall_en,
  input logic          cfg_test_en,
  input logic          bus_wr,
  input logic          eng_tx_valid,
  input logic          eng_tx_ready,
  input logic          eng_rx_ready,
  input logic          eng_master,
  input logic          eng_halt,
  input logic          tx_dma_req,
  input logic          rx_dma_req,
  input logic          err,
  input logic [CW-1:0] tx_level,
  input logic [CW-1:0] rx_level
);

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= CW'(DEPTH) && rx_level <= CW'(DEPTH)); // R2

  AST_TX_DMA_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_tx_dma_en |-> !tx_dma_req); // R7

  AST_RX_DMA_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rx_dma_en |-> !rx_dma_req); // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R8

  AST_TX_OVERFLOW_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !cfg_test_en && tx_level == CW'(DEPTH) && !(eng_tx_valid && eng_tx_ready))
      |=> (tx_level == CW'(DEPTH) && err)); // R8

  AST_HALT_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_stall_en && eng_master && rx_level == CW'(DEPTH)) |-> eng_halt); // R9

  AST_TEST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_test_en |-> (!eng_tx_valid && !eng_rx_ready)); // R10

endmodule

bind spfifo_ctrl spfifo_ctrl_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_tx_dma_en(cfg_tx_dma_en), .cfg_rx_dma_en(cfg_rx_dma_en),
  .cfg_stall_en(cfg_stall_en), .cfg_test_en(cfg_test_en), .bus_wr(bus_wr),
  .eng_tx_valid(eng_tx_valid), .eng_tx_ready(eng_tx_ready), .eng_rx_ready(eng_rx_ready),
  .eng_master(eng_master), .eng_halt(eng_halt), .tx_dma_req(tx_dma_req),
  .rx_dma_req(rx_dma_req), .err(err), .tx_level(tx_level), .rx_level(rx_level)
);

// File: tb/spfifo_ctrl_tb.sv
module spfifo_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int D = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] cfg_tx_lvl = '0, cfg_rx_lvl = '0;
  logic cfg_tx_dma_en = 0, cfg_rx_dma_en = 0, cfg_stall_en = 0, cfg_test_en = 0, cfg_test_sel = 0;
  logic [1:0] cfg_wr_order = '0, cfg_rd_order = '0;
  logic bus_wr = 0, bus_rd = 0, eng_tx_ready = 0, eng_rx_valid = 0, eng_master = 0;
  logic [31:0] bus_wdata = '0, eng_rx_data = '0;
  logic [31:0] bus_rdata, eng_tx_data;
  logic eng_tx_valid, eng_rx_ready, eng_halt, tx_irq, rx_irq, tx_dma_req, rx_dma_req, err;
  logic [5:0] tx_level, rx_level;

  int n_tests = 0, n_fail = 0;
  logic [31:0] tq[$], rq[$];
  logic m_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spfifo_ctrl u_dut (.*);

  function automatic logic [31:0] exp_order(input logic [1:0] m, input logic [31:0] w);
    logic [7:0] b [4];
    for (int i = 0; i < 4; i++) b[i] = w[8*i +: 8];
    if (m == 2'd1) return {b[1], b[0], b[3], b[2]};
    if (m == 2'd2) return {b[0], b[1], b[2], b[3]};
    if (m == 2'd3) return {b[2], b[3], b[0], b[1]};
    return {b[3], b[2], b[1], b[0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    int ts = tq.size(), rs = rq.size();
    logic tsel = cfg_test_en && !cfg_test_sel;
    logic ti = ts <= int'(cfg_tx_lvl) + 1;
    logic ri = rs >= int'(cfg_rx_lvl) + 1;
    chk("R2 tx_level", 32'(tx_level), 32'(ts));
    chk("R2 rx_level", 32'(rx_level), 32'(rs));
    chk("R10 eng_tx_valid", 32'(eng_tx_valid), 32'(!cfg_test_en && ts > 0));
    if (eng_tx_valid && ts > 0) chk("R3 eng_tx_data", eng_tx_data, tq[0]);
    chk("R9 eng_rx_ready", 32'(eng_rx_ready), 32'(!cfg_test_en && rs < D));
    chk("R9 eng_halt", 32'(eng_halt), 32'(cfg_stall_en && eng_master && rs == D));
    chk("R5 tx_irq", 32'(tx_irq), 32'(ti));
    chk("R6 rx_irq", 32'(rx_irq), 32'(ri));
    chk("R7 tx_dma_req", 32'(tx_dma_req), 32'(ti && cfg_tx_dma_en));
    chk("R7 rx_dma_req", 32'(rx_dma_req), 32'(ri && cfg_rx_dma_en));
    chk("R8 err", 32'(err), 32'(m_err));
    if (bus_rd) begin
      if (tsel) chk("R4 bus_rdata", bus_rdata, ts > 0 ? exp_order(cfg_rd_order, tq[0]) : 32'd0);
      else      chk("R4 bus_rdata", bus_rdata, rs > 0 ? exp_order(cfg_rd_order, rq[0]) : 32'd0);
    end
  endtask

  task automatic model_step();
    int ts = tq.size(), rs = rq.size();
    logic [31:0] w = exp_order(cfg_wr_order, bus_wdata);
    if (!cfg_test_en) begin
      if (bus_wr) begin if (ts < D) tq.push_back(w); else m_err = 1; end
      if (eng_tx_ready && ts > 0) void'(tq.pop_front());
      if (eng_rx_valid && rs < D) rq.push_back(eng_rx_data);
      if (bus_rd) begin if (rs > 0) void'(rq.pop_front()); else m_err = 1; end
    end else if (!cfg_test_sel) begin
      if (bus_wr) begin if (ts < D) tq.push_back(w); else m_err = 1; end
      if (bus_rd) begin if (ts > 0) void'(tq.pop_front()); else m_err = 1; end
    end else begin
      if (bus_wr) begin if (rs < D) rq.push_back(w); else m_err = 1; end
      if (bus_rd) begin if (rs > 0) void'(rq.pop_front()); else m_err = 1; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int p_wr, p_rd, p_tp, p_rp;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 tx_level", 32'(tx_level), 0);
    chk("R1 rx_level", 32'(rx_level), 0);
    chk("R1 err", 32'(err), 0);
    chk("R1 tx_irq", 32'(tx_irq), 1);
    chk("R1 rx_irq", 32'(rx_irq), 0);
    chk("R1 eng_halt", 32'(eng_halt), 0);
    chk("R1 eng_tx_valid", 32'(eng_tx_valid), 0);
    chk("R1 dma", 32'({tx_dma_req, rx_dma_req}), 0);

    for (int ph = 0; ph < 10; ph++) begin
      @(negedge clk);
      bus_wr = 0; bus_rd = 0; eng_tx_ready = 0; eng_rx_valid = 0;
      cfg_tx_lvl    = 5'($urandom);
      cfg_rx_lvl    = 5'($urandom);
      cfg_wr_order  = 2'(ph);
      cfg_rd_order  = 2'(ph + 1);
      cfg_tx_dma_en = ph[0];
      cfg_rx_dma_en = !ph[1];
      cfg_stall_en  = (ph != 3);
      eng_master    = (ph != 2);
      cfg_test_en   = (ph == 4 || ph == 5 || ph == 8);
      cfg_test_sel  = (ph == 5 || ph == 8);
      case (ph)
        0:       begin p_wr = 90; p_tp = 5;  p_rp = 90; p_rd = 5;  end
        1:       begin p_wr = 5;  p_tp = 90; p_rp = 5;  p_rd = 90; end
        4, 5:    begin p_wr = 70; p_tp = 50; p_rp = 50; p_rd = 20; end
        8:       begin p_wr = 20; p_tp = 50; p_rp = 50; p_rd = 80; end
        default: begin p_wr = $urandom_range(10, 90); p_tp = $urandom_range(10, 90);
                       p_rp = $urandom_range(10, 90); p_rd = $urandom_range(10, 90); end
      endcase
      for (int c = 0; c < 1500; c++) begin
        if (c > 0) @(negedge clk);
        bus_wr       = $urandom_range(0, 99) < p_wr;
        bus_rd       = $urandom_range(0, 99) < p_rd;
        eng_tx_ready = $urandom_range(0, 99) < p_tp;
        eng_rx_valid = $urandom_range(0, 99) < p_rp;
        bus_wdata    = $urandom;
        eng_rx_data  = $urandom;
        #1;
        check_all();
        model_step();
      end
    end
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; eng_tx_ready = 0; eng_rx_valid = 0;
    #1;
    check_all();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule